// File: doc/BRIEF.md
# Stop-mode wake-up recovery controller

This block decides when a low-power microcontroller leaves STOP. Software programs an 8-bit control register. Its fields pick the pin event that ends STOP and the level that counts as active. They also choose between a long fixed reset after wake-up and a fast wake with no reset, and they switch a divide-by-16 prescaler onto the system and timer clock enables. A read-only flag in the top bit records warm entry: hardware sets it when the device goes into STOP, and only a power-on reset clears it.

A second 8-bit mask, written through its own strobe, enables individual port-2 pins as extra wake sources. These pins use the same polarity bit, and an event from either the main selector or the mask wakes the device. Port-2 pins whose direction bit marks them as outputs never take part in wake detection. All pin inputs pass through a synchronizer before any decision is made. The block emits a one-cycle wake pulse and holds an internal reset for a parameterised number of cycles when the delay is enabled.

Top module: `wake_recovery`

## Requirements
- R1: After power-on reset the control register reads 0x20 (delay bit 5 set, all other bits 0) and the mask reads 0x00. The outputs then are wakePulse=0, coreRst=0, sclkEn=1 and tclkEn=1.
- R2: A write strobe updates control bits 6:0 from wrData, and wrData bit 7 is ignored. regRdData returns all 8 bits and mask2RdData returns the mask.
- R3: Control bit 7 becomes 1 on the clock edge that accepts stopReq while running. It stays 1 through wake-up and is cleared only by porRst.
- R4: Source field bits 4:2 select single-pin wakes. Code 2 selects p3In[1], code 3 selects p3In[2], code 4 selects p3In[3] and code 5 selects p2In[7].
- R5: Source code 6 wakes on the NOR of p2In[3:0] and code 7 wakes on the NOR of p2In[7:0].
- R6: Source codes 0 and 1 select no pin, so only porRst ends STOP unless the mask enables a pin.
- R7: A port-2 pin with p2IsOut set drops out of every wake term. Alone it never causes or blocks a wake, and the remaining input pins of a NOR group decide that group's result.
- R8: Each set mask bit n makes p2In[n] an additional wake source, OR-combined with the main selector.
- R9: Bit 6 sets the polarity. With bit 6 = 1 a source wakes on a high level, and with bit 6 = 0 it wakes on a low level.
- R10: With bit 5 = 1, wakePulse rises on the third clock edge after a pin changes, counting the two synchronizer flops and the accept edge. coreRst then stays high for exactly DELAY_CYC cycles.
- R11: With bit 5 = 0, the source must stay active on QUAL_CYC consecutive synchronized samples before it is accepted, which gives a wake on the seventh edge with the defaults. Shorter activity is dropped, and coreRst stays low.
- R12: wakePulse lasts one cycle and occurs only when the block was in STOP. Pin activity while running has no effect.
- R13: When bit 0 = 1, sclkEn and tclkEn are high once every 16 cycles. Otherwise they are high every cycle. Bit 0 is cleared on every wake-up, and sclkEn is low while in STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Asynchronous power-on reset, active high |
| regWrEn | input | 1 | Write strobe for the control register |
| mask2WrEn | input | 1 | Write strobe for the additional wake mask |
| wrData | input | 8 | Write data for both registers |
| regRdData | output | 8 | Control register contents, including the warm flag |
| mask2RdData | output | 8 | Additional wake mask contents |
| p2In | input | 8 | Port-2 pin levels |
| p2IsOut | input | 8 | Port-2 direction bits, 1 = output |
| p3In | input | 3 | Port-3 pins 1 to 3 |
| stopReq | input | 1 | Request to enter STOP |
| wakePulse | output | 1 | One-cycle wake-up indication |
| coreRst | output | 1 | Internal reset held during the post-wake delay |
| sclkEn | output | 1 | System clock enable (prescaled) |
| tclkEn | output | 1 | Timer clock enable (prescaled) |

## Verification
The bench walks every source code against both polarities. Its vectors include a NOR group in which one member is an output; a design that let that pin vote would miss the wake. Other vectors target the reserved codes and a mask-only wake, and they show whether a design wakes spuriously or ignores the mask. In fast mode, a four-cycle glitch followed by a held level checks the qualifier: a design that miscounts it wakes on the glitch or late. Directed tests measure the exact wake latency and the length of the reset. They also check that bit 0 clears and that bit 7 survives a write, since a design that lets software write the flag would report a false cold start.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_HOLD = 2'd2
  } wake_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterStop;
    logic wakeAccept;
  } ctrl_strb_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 4
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       regWrEn,
  input  logic       mask2WrEn,
  input  logic [7:0] wrData,
  input  logic [7:0] p2In,
  input  logic [7:0] p2IsOut,
  input  logic [3:1] p3In,
  input  ctrl_strb_t strb,
  input  logic       stopped,
  output logic [7:0] ctrlRd,
  output logic [7:0] mask2Rd,
  output logic       srcHit,
  output logic       fastMode,
  output logic       sclkEn,
  output logic       tclkEn
);
  localparam int PIN_W = 11;
  localparam logic [DIV_LOG2-1:0] DIV_MAX = '1;

  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;
  logic [7:0] ctrlQ, mask2Q;
  logic [DIV_LOG2-1:0] divCnt;
  logic [7:0] p2S;
  logic [3:1] p3S;
  logic pol, hitMain, hit2, grpLo, grpAll, divTick;
  logic [2:0] srcSel;

  // pin synchronizer chain
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) syncQ <= '0;
    else begin
      syncQ[0] <= {p3In, p2In};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign {p3S, p2S} = syncQ[SYNC_STAGES-1];

  // control and mask registers
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      ctrlQ  <= CTRL_RESET;
      mask2Q <= '0;
    end else begin
      if (regWrEn)        ctrlQ[6:0] <= wrData[6:0];
      if (strb.wakeAccept) ctrlQ[0]  <= 1'b0;
      if (strb.enterStop)  ctrlQ[7]  <= 1'b1;
      if (mask2WrEn)      mask2Q     <= wrData;
    end
  end

  assign pol      = ctrlQ[6];
  assign fastMode = ~ctrlQ[5];
  assign srcSel   = ctrlQ[4:2];

  // output pins are forced inactive (0) inside NOR groups
  assign grpLo  = ~|(p2S[3:0] & ~p2IsOut[3:0]);
  assign grpAll = ~|(p2S & ~p2IsOut);

  always_comb begin
    hitMain = 1'b0;
    unique case (srcSel)
      3'd2: hitMain = (p3S[1] == pol);
      3'd3: hitMain = (p3S[2] == pol);
      3'd4: hitMain = (p3S[3] == pol);
      3'd5: hitMain = ~p2IsOut[7] & (p2S[7] == pol);
      3'd6: hitMain = (|(~p2IsOut[3:0])) & (grpLo == pol);
      3'd7: hitMain = (|(~p2IsOut)) & (grpAll == pol);
      default: hitMain = 1'b0;
    endcase
  end

  assign hit2   = |(mask2Q & ~p2IsOut & (pol ? p2S : ~p2S));
  assign srcHit = hitMain | hit2;

  // divide-by-16 prescaler
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                          divCnt <= '0;
    else if (strb.wakeAccept || !ctrlQ[0]) divCnt <= '0;
    else                                 divCnt <= divCnt + 1'b1;
  end

  assign divTick = ctrlQ[0] ? (divCnt == DIV_MAX) : 1'b1;
  assign sclkEn  = divTick & ~stopped;
  assign tclkEn  = divTick;
  assign ctrlRd  = ctrlQ;
  assign mask2Rd = mask2Q;
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
#(
  parameter int QUAL_CYC  = 5,
  parameter int DELAY_CYC = 50000
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       stopReq,
  input  logic       srcHit,
  input  logic       fastMode,
  output ctrl_strb_t strb,
  output logic       stopped,
  output logic       wakePulse,
  output logic       coreRst
);
  localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
  localparam int DW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DELAY_CYC - 1);

  wake_state_t stateQ;
  logic [QW-1:0] qualCnt;
  logic [DW-1:0] delayCnt;
  logic accept, wakeQ;

  always_comb begin
    accept = (stateQ == ST_STOP) && srcHit && (!fastMode || qualCnt == Q_LAST);
    strb.enterStop  = (stateQ == ST_RUN) && stopReq;
    strb.wakeAccept = accept;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      stateQ   <= ST_RUN;
      qualCnt  <= '0;
      delayCnt <= '0;
      wakeQ    <= 1'b0;
    end else begin
      wakeQ <= accept;
      if (stateQ == ST_STOP && srcHit && !accept) qualCnt <= qualCnt + 1'b1;
      else                                        qualCnt <= '0;
      unique case (stateQ)
        ST_RUN:  if (stopReq) stateQ <= ST_STOP;
        ST_STOP: if (accept) begin
          stateQ   <= fastMode ? ST_RUN : ST_HOLD;
          delayCnt <= '0;
        end
        ST_HOLD: begin
          if (delayCnt == D_LAST) stateQ <= ST_RUN;
          else                    delayCnt <= delayCnt + 1'b1;
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  assign stopped   = (stateQ == ST_STOP);
  assign wakePulse = wakeQ;
  assign coreRst   = (stateQ == ST_HOLD);
endmodule

// File: rtl/wake_recovery.sv
module wake_recovery
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 5,
  parameter int DELAY_CYC   = 50000,
  parameter int DIV_LOG2    = 4
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       regWrEn,
  input  logic       mask2WrEn,
  input  logic [7:0] wrData,
  output logic [7:0] regRdData,
  output logic [7:0] mask2RdData,
  input  logic [7:0] p2In,
  input  logic [7:0] p2IsOut,
  input  logic [3:1] p3In,
  input  logic       stopReq,
  output logic       wakePulse,
  output logic       coreRst,
  output logic       sclkEn,
  output logic       tclkEn
);
  ctrl_strb_t strb;
  logic inStop, srcHit, fastMode;

  wake_datapath #(.SYNC_STAGES(SYNC_STAGES), .DIV_LOG2(DIV_LOG2)) u_dp (
    .clk(clk), .porRst(porRst), .regWrEn(regWrEn), .mask2WrEn(mask2WrEn),
    .wrData(wrData), .p2In(p2In), .p2IsOut(p2IsOut), .p3In(p3In),
    .strb(strb), .stopped(inStop), .ctrlRd(regRdData), .mask2Rd(mask2RdData),
    .srcHit(srcHit), .fastMode(fastMode), .sclkEn(sclkEn), .tclkEn(tclkEn)
  );

  wake_control #(.QUAL_CYC(QUAL_CYC), .DELAY_CYC(DELAY_CYC)) u_ctl (
    .clk(clk), .porRst(porRst), .stopReq(stopReq), .srcHit(srcHit),
    .fastMode(fastMode), .strb(strb), .stopped(inStop),
    .wakePulse(wakePulse), .coreRst(coreRst)
  );
endmodule

// File: rtl/wake_recovery_chk.sv
module wake_recovery_chk (
  input logic       clk,
  input logic       porRst,
  input logic       wakePulse,
  input logic       coreRst,
  input logic       sclkEn,
  input logic       stopReq,
  input logic       inStop,
  input logic [7:0] ctrlRd
);
  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (porRst)
    wakePulse |=> !wakePulse);
  assert_wake_from_stop_R12: assert property (@(posedge clk) disable iff (porRst)
    wakePulse |-> $past(inStop));
  assert_warm_set_R3: assert property (@(posedge clk) disable iff (porRst)
    $rose(ctrlRd[7]) |-> $past(stopReq));
  assert_warm_hold_R3: assert property (@(posedge clk) disable iff (porRst)
    ctrlRd[7] |=> ctrlRd[7]);
  assert_div_clear_R13: assert property (@(posedge clk) disable iff (porRst)
    wakePulse |-> !ctrlRd[0]);
  assert_stop_clk_R13: assert property (@(posedge clk) disable iff (porRst)
    inStop |-> !sclkEn);
  assert_reset_start_R10: assert property (@(posedge clk) disable iff (porRst)
    $rose(coreRst) |-> (wakePulse && $past(ctrlRd[5])));
endmodule

bind wake_recovery wake_recovery_chk u_chk (
  .clk(clk), .porRst(porRst), .wakePulse(wakePulse), .coreRst(coreRst),
  .sclkEn(sclkEn), .stopReq(stopReq), .inStop(inStop), .ctrlRd(regRdData)
);

// File: tb/wake_recovery_tb.sv
module wake_recovery_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY_CYC  = 8;

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] mask;
    logic [7:0] p2;
    logic [7:0] out;
    logic [2:0] p3;   // p3In[3:1]
    logic       exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{8'h68, 8'h00, 8'h00, 8'h00, 3'b001, 1'b1}, // R4 code2 high
    '{8'h68, 8'h00, 8'h00, 8'h00, 3'b010, 1'b0}, // R4 code2 other pin
    '{8'h2C, 8'h00, 8'h00, 8'h00, 3'b101, 1'b1}, // R9 code3 low
    '{8'h70, 8'h00, 8'h00, 8'h00, 3'b100, 1'b1}, // R4 code4
    '{8'h74, 8'h00, 8'h80, 8'h80, 3'b000, 1'b0}, // R7 code5 output pin
    '{8'h74, 8'h00, 8'h80, 8'h00, 3'b000, 1'b1}, // R4 code5
    '{8'h78, 8'h00, 8'hF0, 8'h00, 3'b000, 1'b1}, // R5 code6 nibble zero
    '{8'h78, 8'h00, 8'h02, 8'h00, 3'b000, 1'b0}, // R5 code6 one high
    '{8'h78, 8'h00, 8'h02, 8'h02, 3'b000, 1'b1}, // R7 high pin is output
    '{8'h7C, 8'h00, 8'h80, 8'h00, 3'b000, 1'b0}, // R5 code7
    '{8'h3C, 8'h00, 8'h80, 8'h00, 3'b000, 1'b1}, // R9 code7 low polarity
    '{8'h60, 8'h00, 8'hFF, 8'h00, 3'b111, 1'b0}, // R6 code0
    '{8'h64, 8'h00, 8'hFF, 8'h00, 3'b111, 1'b0}, // R6 code1
    '{8'h60, 8'h08, 8'h08, 8'h00, 3'b000, 1'b1}, // R8 mask only
    '{8'h60, 8'h08, 8'h08, 8'h08, 3'b000, 1'b0}, // R7 mask pin output
    '{8'h68, 8'h01, 8'h01, 8'h00, 3'b000, 1'b1}  // R8 either source
  };

  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic regWrEn = 1'b0, mask2WrEn = 1'b0, stopReq = 1'b0;
  logic [7:0] wrData = '0, p2In = '0, p2IsOut = '0;
  logic [3:1] p3In = '0;
  logic [7:0] regRdData, mask2RdData;
  logic wakePulse, coreRst, sclkEn, tclkEn;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_recovery #(.DELAY_CYC(DELAY_CYC)) u_dut (
    .clk(clk), .porRst(porRst), .regWrEn(regWrEn), .mask2WrEn(mask2WrEn),
    .wrData(wrData), .regRdData(regRdData), .mask2RdData(mask2RdData),
    .p2In(p2In), .p2IsOut(p2IsOut), .p3In(p3In), .stopReq(stopReq),
    .wakePulse(wakePulse), .coreRst(coreRst), .sclkEn(sclkEn), .tclkEn(tclkEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic por();
    @(negedge clk); porRst = 1'b1;
    repeat (2) @(negedge clk);
    porRst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    wrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic wrMask(input logic [7:0] d);
    wrData = d; mask2WrEn = 1'b1;
    @(negedge clk); mask2WrEn = 1'b0;
  endtask

  task automatic enterStop();
    stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int lat, cnt, pulses;
    // R1 reset state
    por();
    check(regRdData == 8'h20, "R1 ctrl", regRdData, 8'h20);
    check(mask2RdData == 8'h00, "R1 mask", mask2RdData, 0);
    check({wakePulse, coreRst, sclkEn, tclkEn} == 4'b0011, "R1 outputs",
          {wakePulse, coreRst, sclkEn, tclkEn}, 4'b0011);

    // R2 bit 7 not writable
    wrCtrl(8'hFF);
    check(regRdData == 8'h7F, "R2 write", regRdData, 8'h7F);
    wrMask(8'hA5);
    check(mask2RdData == 8'hA5, "R2 mask read", mask2RdData, 8'hA5);

    // vector table: R4..R9
    for (int i = 0; i < NVEC; i++) begin
      por();
      p2In = VEC[i].p2; p2IsOut = VEC[i].out; p3In = VEC[i].p3;
      wrCtrl(VEC[i].ctrl);
      wrMask(VEC[i].mask);
      enterStop();
      pulses = 0;
      repeat (15) begin
        if (wakePulse) pulses++;
        @(negedge clk);
      end
      check(pulses == int'(VEC[i].exp), $sformatf("R4-vector %0d (R5 R6 R7 R8 R9)", i),
            pulses, int'(VEC[i].exp));
    end
    p2In = '0; p2IsOut = '0; p3In = '0;

    // R12 pin activity while running ignored
    por();
    p3In = 3'b001;
    wrCtrl(8'h68);
    pulses = 0;
    repeat (10) begin if (wakePulse) pulses++; @(negedge clk); end
    check(pulses == 0, "R12 running", pulses, 0);

    // R10 delay mode latency and reset length, R3, R13
    por();
    p3In = '0;
    wrCtrl(8'h69);
    enterStop();
    check(regRdData[7] == 1'b1, "R3 warm set", regRdData[7], 1);
    check(sclkEn == 1'b0, "R13 stop sclk", sclkEn, 0);
    p3In = 3'b001;
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (wakePulse && lat == 0) lat = k;
      if (lat != 0) break;
    end
    check(lat == 3, "R10 latency", lat, 3);
    check(regRdData[0] == 1'b0, "R13 div cleared", regRdData[0], 0);
    cnt = 0; pulses = 0;
    for (int k = 0; k < 30; k++) begin
      if (coreRst) cnt++;
      if (wakePulse) pulses++;
      @(negedge clk);
    end
    check(cnt == DELAY_CYC, "R10 reset length", cnt, DELAY_CYC);
    check(pulses == 1, "R12 one pulse", pulses, 1);
    check(regRdData[7] == 1'b1, "R3 warm kept", regRdData[7], 1);
    wrCtrl(8'h00);
    check(regRdData[7] == 1'b1, "R3 write keeps flag", regRdData[7], 1);
    por();
    check(regRdData[7] == 1'b0, "R3 cold", regRdData[7], 0);

    // R11 fast mode qualifier
    p3In = '0;
    wrCtrl(8'h48);
    enterStop();
    p3In = 3'b001;
    repeat (4) @(negedge clk);
    p3In = '0;
    pulses = 0;
    repeat (12) begin if (wakePulse) pulses++; @(negedge clk); end
    check(pulses == 0, "R11 glitch", pulses, 0);
    p3In = 3'b001;
    lat = 0; cnt = 0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (wakePulse && lat == 0) lat = k;
      if (coreRst) cnt++;
    end
    check(lat == 7, "R11 latency", lat, 7);
    check(cnt == 0, "R11 no reset", cnt, 0);

    // R13 prescaler
    por();
    p3In = '0;
    wrCtrl(8'h21);
    cnt = 0; pulses = 0;
    repeat (64) begin
      if (sclkEn) cnt++;
      if (tclkEn) pulses++;
      @(negedge clk);
    end
    check(cnt == 4, "R13 sclk div", cnt, 4);
    check(pulses == 4, "R13 tclk div", pulses, 4);
    wrCtrl(8'h20);
    check(sclkEn && tclkEn, "R13 undivided", {sclkEn, tclkEn}, 3);

    summary();
  end
endmodule